// File: doc/BRIEF.md
# Selectable-Word NCO Quadrature Mixer

This block is a numerically controlled oscillator that puts signed baseband I and Q samples onto a carrier and produces one real output sample every clock. It keeps three programmable frequency words. A load strobe copies one of them, chosen by a select input, into the active word. That active word is added to a phase accumulator every clock. The top bits of the phase address a quarter-wave sine table, and the table is folded over the four quadrants to give both sine and cosine.

The output is I·cos + Q·sin, scaled down and clipped to the output width. Spectrum inversion negates the I·cos term, which swaps the sidebands. Freezing the sine path removes the Q·sin term, so the constellation collapses onto the I axis. In continuous-wave mode a full-scale positive I and a zero Q stand in for the input samples, so the output is an unmodulated carrier.

A three-state controller sequences the block:
- HOLD is the reset state. The phase stays at zero and the output is zero.
- HOLD goes to MIX on a valid load while `cw_mode` is low.
- HOLD goes to TONE on a valid load while `cw_mode` is high.
- MIX goes to TONE when `cw_mode` is high.
- TONE goes back to MIX when `cw_mode` is low.
- Only reset returns the controller to HOLD.

Top module: `nco_quad_mixer`

## Requirements
- R1: After reset, and for as long as the controller stays in HOLD, `y_out` is 0 and the phase accumulator holds 0 whatever the sample inputs are.
- R2: `wr_en` with `wr_addr` 0, 1 or 2 writes `wr_data` into that frequency word. A write with `wr_addr` 3 is ignored. A write never changes the running frequency until a later load.
- R3: `load` with `load_sel` 0 to 2 copies that word into the active word. `load` with `load_sel` 3 leaves the active word and the state unchanged.
- R4: Outside HOLD, the phase advances by the active word every clock, modulo 2^24. On the clock that leaves HOLD the phase is still 0.
- R5: With p = phase[23:16], sine = round(511·sin(2π(p+0.5)/256)) and cosine = round(511·cos(2π(p+0.5)/256)). Both come from a 64-entry quarter-wave table that is folded by quadrant.
- R6: In MIX, y = clip(floor((I·cos + Q·sin)/512)). The phase, state and inputs present at one clock edge appear on `y_out` after the following edge, so the latency is two registers.
- R7: When `invert` is high, the I·cos term is negated.
- R8: When `freeze_sin` is high, the Q·sin term is dropped.
- R9: In TONE, I is replaced by +511 and Q by 0. `invert` and `freeze_sin` still apply.
- R10: The result is clipped to the range -512 to 511 rather than wrapped.
- R11: The controller makes only the transitions HOLD→MIX, HOLD→TONE, MIX→TONE and TONE→MIX listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Frequency word write enable |
| wr_addr | input | 2 | Frequency word index (0-2 valid) |
| wr_data | input | 24 | Frequency word value |
| load | input | 1 | Strobe: activate the selected word |
| load_sel | input | 2 | Word chosen by the load strobe (0-2 valid) |
| cw_mode | input | 1 | Unmodulated carrier mode |
| invert | input | 1 | Spectrum inversion |
| freeze_sin | input | 1 | Drop the sine path |
| i_in | input | 10 | Signed in-phase sample |
| q_in | input | 10 | Signed quadrature sample |
| y_out | output | 10 | Signed mixed output sample |

## Verification
The assertions check several properties on every clock:
- The phase steps by exactly the active word outside HOLD and stays at zero inside it.
- The active word moves only on a valid load.
- The output is zero whenever the controller was in HOLD two clocks earlier.
- A frozen sine path with zero I gives a zero output.

The bench scenarios carry the rest:
- the numerical result at every table phase;
- the exact rounding of the folded table;
- clipping at both rails;
- the effect of inversion and of continuous-wave mode;
- the fact that a rewritten word leaves the carrier alone until the next load.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    typedef enum logic [1:0] {
        S_HOLD = 2'd0,
        S_MIX  = 2'd1,
        S_TONE = 2'd2
    } nco_state_e;

    // Rounded quarter-wave sample, offset by half a step so folding needs no end fix-up.
    function automatic int quarter_sine(input int k, input int entries, input int amp);
        real ang;
        ang = 3.14159265358979 / 2.0 * (real'(k) + 0.5) / real'(entries);
        return int'(real'(amp) * $sin(ang));
    endfunction

endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank #(
    parameter int PHASE_W   = 24,
    parameter int NUM_WORDS = 3,
    localparam int SEL_W    = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_addr,
    input  logic [PHASE_W-1:0] wr_data,
    input  logic               load,
    input  logic [SEL_W-1:0]   sel,
    output logic [PHASE_W-1:0] active_word,
    output logic               load_ok
);
    localparam logic [SEL_W:0] NW = (SEL_W+1)'(NUM_WORDS);

    logic [PHASE_W-1:0] word_q [NUM_WORDS];
    logic [PHASE_W-1:0] picked;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[w] <= '0;
            else if (wr_en && wr_addr == SEL_W'(w))
                word_q[w] <= wr_data;
        end
    end

    always_comb begin
        picked = '0;
        for (int w = 0; w < NUM_WORDS; w++)
            if (sel == SEL_W'(w)) picked = word_q[w];
    end

    assign load_ok = load && ({1'b0, sel} < NW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            active_word <= '0;
        else if (load_ok)
            active_word <= picked;
    end

    // An out-of-range selection must not disturb the running word.
    assert_bad_sel_keeps_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ({1'b0, sel} >= NW)) |=> $stable(active_word));

    // Only the strobe moves the active word; writes alone never do.
    assert_word_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_word));

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
    parameter int ADDR_W = 6,
    parameter int AMP_W  = 10
) (
    input  logic [ADDR_W+1:0]        ph_idx,
    output logic signed [AMP_W-1:0]  sin_val,
    output logic signed [AMP_W-1:0]  cos_val
);
    import nco_mix_pkg::*;

    localparam int QN  = 1 << ADDR_W;
    localparam int AMP = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-1:0] rom [QN];

    for (genvar k = 0; k < QN; k++) begin : g_rom
        assign rom[k] = AMP_W'(quarter_sine(k, QN, AMP));
    end

    logic [ADDR_W+1:0] cos_idx;
    logic [ADDR_W-1:0] s_addr, c_addr;
    logic [AMP_W-1:0]  s_mag, c_mag;

    always_comb begin
        cos_idx = ph_idx + (ADDR_W+2)'(QN);
        // odd quadrants read the table backwards, upper half negates
        s_addr  = ph_idx[ADDR_W-1:0] ^ {ADDR_W{ph_idx[ADDR_W]}};
        c_addr  = cos_idx[ADDR_W-1:0] ^ {ADDR_W{cos_idx[ADDR_W]}};
        s_mag   = rom[s_addr];
        c_mag   = rom[c_addr];
        sin_val = ph_idx[ADDR_W+1]  ? -$signed(s_mag) : $signed(s_mag);
        cos_val = cos_idx[ADDR_W+1] ? -$signed(c_mag) : $signed(c_mag);
    end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
    parameter int DATA_W = 10,
    parameter int AMP_W  = 10,
    parameter int OUT_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     tone,
    input  logic                     invert,
    input  logic                     freeze_sin,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    input  logic signed [AMP_W-1:0]  sin_val,
    input  logic signed [AMP_W-1:0]  cos_val,
    output logic signed [OUT_W-1:0]  y_out
);
    localparam int PROD_W = DATA_W + AMP_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic signed [DATA_W-1:0] I_FULL = DATA_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0]  Y_MAX  = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0]  Y_MIN  = -Y_MAX - SUM_W'(1);

    logic                     s1_on, s1_inv, s1_frz;
    logic signed [DATA_W-1:0] s1_i, s1_q;
    logic signed [AMP_W-1:0]  s1_sin, s1_cos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_on  <= 1'b0;
            s1_inv <= 1'b0;
            s1_frz <= 1'b0;
            s1_i   <= '0;
            s1_q   <= '0;
            s1_sin <= '0;
            s1_cos <= '0;
        end else begin
            s1_on  <= run;
            s1_inv <= invert;
            s1_frz <= freeze_sin;
            s1_i   <= tone ? I_FULL : i_in;
            s1_q   <= tone ? '0 : q_in;
            s1_sin <= sin_val;
            s1_cos <= cos_val;
        end
    end

    logic signed [PROD_W-1:0] p_i, p_q, t_i;
    logic signed [SUM_W-1:0]  sum, scaled, clipped;

    always_comb begin
        p_i     = PROD_W'(s1_i) * PROD_W'(s1_cos);
        p_q     = PROD_W'(s1_q) * PROD_W'(s1_sin);
        t_i     = s1_inv ? -p_i : p_i;
        sum     = SUM_W'(t_i) + (s1_frz ? '0 : SUM_W'(p_q));
        scaled  = sum >>> (DATA_W - 1);
        if (scaled > Y_MAX)
            clipped = Y_MAX;
        else if (scaled < Y_MIN)
            clipped = Y_MIN;
        else
            clipped = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            y_out <= '0;
        else
            y_out <= s1_on ? clipped[OUT_W-1:0] : '0;
    end

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_on |=> (y_out == '0));

    assert_frozen_iaxis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_on && s1_frz && s1_i == '0) |=> (y_out == '0));

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer #(
    parameter int PHASE_W    = 24,
    parameter int NUM_WORDS  = 3,
    parameter int LUT_ADDR_W = 6,
    parameter int LUT_W      = 10,
    parameter int DATA_W     = 10,
    parameter int OUT_W      = 10,
    localparam int SEL_W     = $clog2(NUM_WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_addr,
    input  logic [PHASE_W-1:0]       wr_data,
    input  logic                     load,
    input  logic [SEL_W-1:0]         load_sel,
    input  logic                     cw_mode,
    input  logic                     invert,
    input  logic                     freeze_sin,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    output logic signed [OUT_W-1:0]  y_out
);
    import nco_mix_pkg::*;

    localparam int IDX_W = LUT_ADDR_W + 2;

    logic [PHASE_W-1:0]      active_word;
    logic                    load_ok;
    nco_state_e              state_q, state_d;
    logic                    run, tone;
    logic [PHASE_W-1:0]      phase_q;
    logic signed [LUT_W-1:0] sin_val, cos_val;

    nco_word_bank #(.PHASE_W(PHASE_W), .NUM_WORDS(NUM_WORDS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load        (load),
        .sel         (load_sel),
        .active_word (active_word),
        .load_ok     (load_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HOLD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HOLD:  if (load_ok) state_d = cw_mode ? S_TONE : S_MIX;
            S_MIX:   if (cw_mode) state_d = S_TONE;
            S_TONE:  if (!cw_mode) state_d = S_MIX;
            default: state_d = S_HOLD;
        endcase
    end

    // state-decoded controls
    always_comb begin
        run  = 1'b0;
        tone = 1'b0;
        unique case (state_q)
            S_HOLD:  ;
            S_MIX:   run = 1'b1;
            S_TONE:  begin run = 1'b1; tone = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase_q <= '0;
        else if (!run) phase_q <= '0;
        else          phase_q <= phase_q + active_word;
    end

    nco_sine_lut #(.ADDR_W(LUT_ADDR_W), .AMP_W(LUT_W)) u_lut (
        .ph_idx  (phase_q[PHASE_W-1 -: IDX_W]),
        .sin_val (sin_val),
        .cos_val (cos_val)
    );

    nco_mixer #(.DATA_W(DATA_W), .AMP_W(LUT_W), .OUT_W(OUT_W)) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tone       (tone),
        .invert     (invert),
        .freeze_sin (freeze_sin),
        .i_in       (i_in),
        .q_in       (q_in),
        .sin_val    (sin_val),
        .cos_val    (cos_val),
        .y_out      (y_out)
    );

    assert_hold_phase_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |-> (phase_q == '0));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_HOLD) |=> (phase_q == $past(phase_q + active_word)));

    assert_no_return_to_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_HOLD) |=> (state_q != S_HOLD));

endmodule

// File: tb/nco_quad_mixer_tb.sv
module nco_quad_mixer_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [23:0]       wr_data = '0;
    logic              load = 1'b0;
    logic [1:0]        load_sel = '0;
    logic              cw_mode = 1'b0;
    logic              invert = 1'b0;
    logic              freeze_sin = 1'b0;
    logic signed [9:0] i_in = '0;
    logic signed [9:0] q_in = '0;
    logic signed [9:0] y_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nco_quad_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(load), .load_sel(load_sel), .cw_mode(cw_mode), .invert(invert),
        .freeze_sin(freeze_sin), .i_in(i_in), .q_in(q_in), .y_out(y_out)
    );

    // ---------------- independent reference model ----------------
    // state coding of the model: 0 hold, 1 modulated, 2 carrier only
    logic [23:0] m_w [3];
    logic [23:0] m_aw, m_ph;
    int          m_st, m_y1, m_y2;

    function automatic int model_y(input logic [23:0] ph, input int st,
                                   input logic signed [9:0] ii, input logic signed [9:0] qq,
                                   input logic inv, input logic frz);
        real ang;
        int  p, s, c, iv, qv, t;
        if (st == 0) return 0;
        p   = int'(ph[23:16]);
        ang = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0;
        s   = int'(511.0 * $sin(ang));
        c   = int'(511.0 * $cos(ang));
        iv  = (st == 2) ? 511 : int'(ii);
        qv  = (st == 2) ? 0 : int'(qq);
        t   = iv * c;
        if (inv) t = -t;
        if (!frz) t = t + qv * s;
        t = t >>> 9;
        if (t > 511) t = 511;
        if (t < -512) t = -512;
        return t;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_w[0] <= '0; m_w[1] <= '0; m_w[2] <= '0;
            m_aw <= '0; m_ph <= '0; m_st <= 0; m_y1 <= 0; m_y2 <= 0;
        end else begin
            m_y1 <= model_y(m_ph, m_st, i_in, q_in, invert, freeze_sin);
            m_y2 <= m_y1;
            m_ph <= (m_st == 0) ? 24'd0 : m_ph + m_aw;
            if (wr_en && wr_addr != 2'd3) m_w[wr_addr] <= wr_data;
            if (load && load_sel != 2'd3) m_aw <= m_w[load_sel];
            case (m_st)
                0: if (load && load_sel != 2'd3) m_st <= cw_mode ? 2 : 1;
                1: if (cw_mode) m_st <= 2;
                default: if (!cw_mode) m_st <= 1;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag);
        n_chk++;
        if (int'(y_out) != m_y2) begin
            n_fail++;
            $display("FAIL %s: y_out=%0d expected %0d", tag, y_out, m_y2);
        end
    endtask

    task automatic cyc(input string tag);
        @(negedge clk);
        chk(tag);
    endtask

    task automatic put_word(input logic [1:0] a, input logic [23:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [1:0] s, input string tag);
        load = 1'b1; load_sel = s;
        cyc(tag);
        load = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]        sel;
        logic signed [9:0] i;
        logic signed [9:0] q;
        logic              cw;
        logic              inv;
        logic              frz;
        logic [9:0]        n;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{2'd0,  10'sd300, -10'sd200, 1'b0, 1'b0, 1'b0, 10'd260},  // R6 R5 full sweep
        '{2'd0,  10'sd300, -10'sd200, 1'b0, 1'b1, 1'b0, 10'd260},  // R7
        '{2'd0,  10'sd300, -10'sd200, 1'b0, 1'b0, 1'b1, 10'd260},  // R8
        '{2'd0,  10'sd511,  10'sd511, 1'b0, 1'b0, 1'b0, 10'd260},  // R10 top rail
        '{2'd0, -10'sd512, -10'sd512, 1'b0, 1'b0, 1'b0, 10'd260},  // R10 bottom rail
        '{2'd1, -10'sd123,  10'sd77,  1'b0, 1'b0, 1'b0, 10'd200},  // R4 odd step
        '{2'd2,  10'sd50,   10'sd400, 1'b1, 1'b0, 1'b0, 10'd40},   // R9 carrier
        '{2'd3,  10'sd200,  10'sd200, 1'b0, 1'b0, 1'b0, 10'd60},   // R3 bad select
        '{2'd2,  10'sd0,    10'sd450, 1'b1, 1'b1, 1'b1, 10'd40}    // R9 with inv/freeze
    };
    string vtag [NV] = '{"R6", "R7", "R8", "R10", "R10", "R4", "R9", "R3", "R9"};

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1");
        i_in = 10'sd200; q_in = -10'sd100;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) cyc("R1");       // hold: no load yet, still silent

        // R2: program the words; address 3 must be dropped
        put_word(2'd0, 24'h010000, "R2");
        put_word(2'd1, 24'h0A3456, "R2");
        put_word(2'd2, 24'h400000, "R2");
        put_word(2'd3, 24'hFFFFFF, "R2");
        for (int k = 0; k < 3; k++) cyc("R11");      // writes alone keep HOLD

        // R11: invalid select from HOLD must not start the oscillator
        strobe(2'd3, "R11");
        for (int k = 0; k < 4; k++) cyc("R11");

        // table walk
        for (int v = 0; v < NV; v++) begin
            i_in = VT[v].i; q_in = VT[v].q;
            cw_mode = VT[v].cw; invert = VT[v].inv; freeze_sin = VT[v].frz;
            strobe(VT[v].sel, vtag[v]);
            for (int k = 0; k < int'(VT[v].n); k++) cyc(vtag[v]);
        end
        cw_mode = 1'b0; invert = 1'b0; freeze_sin = 1'b0;

        // R2: rewriting a word leaves the carrier alone until the next strobe
        strobe(2'd0, "R2");
        put_word(2'd0, 24'h030000, "R2");
        i_in = 10'sd400; q_in = 10'sd0;
        for (int k = 0; k < 40; k++) cyc("R2");
        strobe(2'd0, "R2");
        for (int k = 0; k < 40; k++) cyc("R2");

        // R11 / R9: toggle carrier mode mid-run
        cw_mode = 1'b1;
        for (int k = 0; k < 20; k++) cyc("R11");
        cw_mode = 1'b0;
        for (int k = 0; k < 20; k++) cyc("R11");

        // R1: reset mid-run returns to silent HOLD
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1");
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) cyc("R1");

        summary();
        $finish;
    end

endmodule